// File: doc/BRIEF.md
# Trimmed Timekeeping Prescaler

This block sits between a 32,768 Hz oscillator enable and a clock/calendar. It counts oscillator ticks down to a once-per-second pulse for the seconds counter. It also produces a free-running 512 Hz square wave, so the oscillator frequency can be measured on a pin. The calendar feeds back its once-per-minute pulse. The block uses that pulse to step a 6-bit position within a repeating 64-minute trim period.

A signed trim is applied in the stage that counts 256-tick blocks. The trim has a 5-bit magnitude and a direction bit. In the first second of each trimmed minute, a slowing trim freezes the prescaler for 128 ticks. A speeding trim counts one extra 256-tick block. Only minutes whose position in the period is below twice the magnitude are trimmed, and each gets one correction. The square wave comes from a counter that the trim never touches. A clear strobe, raised when the seconds or control settings are rewritten, restarts the whole chain. Dropping the oscillator enable freezes every counter.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: With no trim pending, consecutive `sec_tick` pulses are exactly 2^(BLK_W+SEC_W) enabled ticks apart. That is 32,768 ticks with the defaults. Each pulse lasts one clock cycle, in the cycle whose tick completes the second.
- R2: `ft_wave` is bit 5 of a 6-bit counter of enabled ticks. It therefore changes level every 32 enabled ticks (512 Hz at 32,768 Hz). Its spacing is the same whether or not a trim is in progress.
- R3: With `trim_up` = 0, the second that starts at a `minute_tick` into a trimmed minute lasts 128 ticks longer than nominal.
- R4: With `trim_up` = 1, that second lasts 256 ticks less than nominal.
- R5: `trim_pos` increments by one on each `minute_tick` and wraps from 63 to 0.
- R6: A minute is trimmed only when its new `trim_pos` value is below 2 × `trim_mag` and below 62. A magnitude of 0 never trims, whatever the direction bit.
- R7: While `div_clr` is high, the prescaler and the square-wave counter clear. The next `sec_tick` then comes a full nominal second of ticks after the clear, and `ft_wave` is low right after it.
- R8: While `osc_en` is low, no counter advances, `sec_tick` stays low and `ft_wave` holds its level.
- R9: After reset, `sec_tick` = 0, `ft_wave` = 0 and `trim_pos` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| osc_en | input | 1 | Oscillator running; low freezes the chain |
| trim_mag | input | 5 | Trim magnitude, 0 to 31 |
| trim_up | input | 1 | 1 = speed up (count an extra block), 0 = slow down (freeze) |
| div_clr | input | 1 | Restart strobe for the prescaler and square wave |
| minute_tick | input | 1 | Minute pulse from the calendar |
| sec_tick | output | 1 | One-cycle pulse per second |
| ft_wave | output | 1 | 512 Hz square wave |
| trim_pos | output | 6 | Minute position inside the 64-minute trim period |

## Verification
The bench shrinks the seconds stage, so a second is 2048 ticks, and measures second lengths directly. It expects 2048 with no trim, 2176 for a slowing trim and 1792 for a speeding trim. A design that trimmed with the wrong sign, or by the wrong block size, would produce one of the other lengths.

Eligibility edges are probed at magnitude 1 (positions 1 and 2) and magnitude 31 (positions 61 and 62). They are also probed at magnitude 0 with each direction. An off-by-one compare would trim a minute it should skip, or skip one it should trim.

A monitor checks every square-wave half period while a trim runs, so a wave derived from the trimmed counter would show a stretched half period. The clear and enable tests catch a chain that keeps stale fractional counts across a clear, or that ticks while the oscillator is stopped.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  typedef enum logic [1:0] {
    TRIM_IDLE = 2'd0,
    TRIM_SLOW = 2'd1,
    TRIM_FAST = 2'd2
  } trim_mode_e;
endpackage

// File: rtl/rtc_wave_div.sv
module rtc_wave_div #(
  parameter int WAVE_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic clr,
  output logic wave
);
  logic [WAVE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign wave = cnt_q[WAVE_W-1];

  // R8: no advance, no clear -> wave level held
  a_r8_wave_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(wave));
endmodule

// File: rtl/rtc_trim_seq.sv
module rtc_trim_seq #(
  parameter int POS_W = 6,
  parameter int MAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             minute_tick,
  input  logic [MAG_W-1:0] mag,
  input  logic             done,
  output logic             pend,
  output logic [POS_W-1:0] pos
);
  localparam int CMP_W   = ((POS_W > MAG_W + 1) ? POS_W : MAG_W + 1) + 1;
  localparam int ELIG_LIM = (1 << POS_W) - 2;

  logic [POS_W-1:0] pos_q, pos_d, pos_inc;
  logic             pend_q, pend_d, elig;

  always_comb begin
    pos_inc = pos_q + 1'b1;
    elig    = (CMP_W'(pos_inc) < CMP_W'({mag, 1'b0})) &&
              (CMP_W'(pos_inc) < CMP_W'(ELIG_LIM));
    pos_d   = pos_q;
    pend_d  = pend_q;
    if (done) pend_d = 1'b0;
    if (minute_tick) begin
      pos_d = pos_inc;
      if (elig) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      pend_q <= pend_d;
    end
  end

  assign pos  = pos_q;
  assign pend = pend_q;

  // R5: position steps by one per minute pulse
  a_r5_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
    minute_tick |=> (pos == POS_W'($past(pos) + 1'b1)));
  // R6: a trim is only armed by a minute pulse into an eligible slot
  a_r6_arm_elig: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> ($past(minute_tick) && ($past(mag) != '0) &&
                     (CMP_W'(pos) < CMP_W'({$past(mag), 1'b0}))));
endmodule

// File: rtl/rtc_block_div.sv
module rtc_block_div
  import rtc_trim_pkg::*;
#(
  parameter int BLK_W = 8,
  parameter int SEC_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       clr,
  input  trim_mode_e mode,
  output logic       sec_tick,
  output logic       done
);
  localparam int GAP_W = BLK_W - 1;

  logic [BLK_W-1:0] blk_q, blk_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [SEC_W:0]   sum;
  logic             freeze, carry;

  always_comb begin
    freeze   = (mode == TRIM_SLOW);
    carry    = (blk_q == '1);
    sum      = {1'b0, sec_q} + (SEC_W+1)'(1) + (SEC_W+1)'(mode == TRIM_FAST);
    blk_d    = blk_q;
    sec_d    = sec_q;
    gap_d    = gap_q;
    done     = 1'b0;
    sec_tick = 1'b0;
    if (clr) begin
      blk_d = '0;
      sec_d = '0;
      gap_d = '0;
    end else if (adv) begin
      if (freeze) begin
        gap_d = gap_q + 1'b1;
        done  = (gap_q == '1);
      end else begin
        blk_d = blk_q + 1'b1;
        if (carry) begin
          sec_d    = sum[SEC_W-1:0];
          sec_tick = sum[SEC_W];
          done     = (mode == TRIM_FAST);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      sec_q <= '0;
      gap_q <= '0;
    end else begin
      blk_q <= blk_d;
      sec_q <= sec_d;
      gap_q <= gap_d;
    end
  end

  // R3: block counter frozen while a slowing trim consumes ticks
  a_r3_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIM_SLOW && adv && !clr) |=> $stable(blk_q));
  // R8: no second pulse without an advancing tick
  a_r8_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |-> !sec_tick);
endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
  import rtc_trim_pkg::*;
#(
  parameter int BLK_W  = 8,
  parameter int SEC_W  = 7,
  parameter int WAVE_W = 6,
  parameter int POS_W  = 6,
  parameter int MAG_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             osc_en,
  input  logic [MAG_W-1:0] trim_mag,
  input  logic             trim_up,
  input  logic             div_clr,
  input  logic             minute_tick,
  output logic             sec_tick,
  output logic             ft_wave,
  output logic [POS_W-1:0] trim_pos
);
  logic       adv, pend, done;
  trim_mode_e mode;

  assign adv  = osc_tick && osc_en;
  assign mode = !pend ? TRIM_IDLE : (trim_up ? TRIM_FAST : TRIM_SLOW);

  rtc_wave_div #(.WAVE_W(WAVE_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .adv(adv), .clr(div_clr), .wave(ft_wave)
  );

  rtc_trim_seq #(.POS_W(POS_W), .MAG_W(MAG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .minute_tick(minute_tick), .mag(trim_mag),
    .done(done), .pend(pend), .pos(trim_pos)
  );

  rtc_block_div #(.BLK_W(BLK_W), .SEC_W(SEC_W)) u_blk (
    .clk(clk), .rst_n(rst_n), .adv(adv), .clr(div_clr), .mode(mode),
    .sec_tick(sec_tick), .done(done)
  );

  // R8: second pulse only while oscillator runs
  a_r8_osc_gate: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> osc_en);
  // R1: second pulse lasts a single cycle when ticks arrive every cycle
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !div_clr) |=> !sec_tick);
endmodule

// File: tb/tb_rtc_trim_prescaler.sv
`timescale 1ns/1ps
module tb_rtc_trim_prescaler;
  localparam int SEC_W = 3;
  localparam int NOM   = 1 << (8 + SEC_W);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b1;
  logic       osc_en = 1'b1;
  logic [4:0] trim_mag = '0;
  logic       trim_up = 1'b0;
  logic       div_clr = 1'b0;
  logic       minute_tick = 1'b0;
  logic       sec_tick, ft_wave;
  logic [5:0] trim_pos;

  int checks = 0, failures = 0, exp_pos = 0;
  int ft_bad = 0, ft_tog = 0, gap = 0;
  bit gap_ok = 0;
  logic ft_prev = 1'b0;

  always #2.5 clk = ~clk;

  rtc_trim_prescaler #(.SEC_W(SEC_W)) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .osc_en(osc_en),
    .trim_mag(trim_mag), .trim_up(trim_up), .div_clr(div_clr),
    .minute_tick(minute_tick), .sec_tick(sec_tick), .ft_wave(ft_wave),
    .trim_pos(trim_pos)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2 monitor: every half period of the square wave is 32 ticks
  always begin
    @(negedge clk); #1;
    if (!rst_n || !osc_en || div_clr) begin
      gap_ok = 0; gap = 0;
    end else begin
      gap++;
      if (ft_wave != ft_prev) begin
        ft_tog++;
        if (gap_ok && gap != 32) ft_bad++;
        gap_ok = 1; gap = 0;
      end
    end
    ft_prev = ft_wave;
  end

  task automatic wait_sec(input bit with_min, output int n);
    minute_tick = with_min;
    if (with_min) exp_pos = (exp_pos + 1) % 64;
    @(posedge clk); n = 1; @(negedge clk);
    minute_tick = 1'b0;
    while (!sec_tick) begin
      @(posedge clk); n++; @(negedge clk);
    end
  endtask

  // step position with oscillator stopped and trim disarmed; leave one pulse
  task automatic set_pos(input int target, input int mag, input bit up);
    osc_en = 1'b0; trim_mag = '0;
    while (((exp_pos + 1) % 64) != target) begin
      minute_tick = 1'b1; @(negedge clk); minute_tick = 1'b0;
      exp_pos = (exp_pos + 1) % 64; @(negedge clk);
    end
    trim_mag = 5'(mag); trim_up = up; osc_en = 1'b1; @(negedge clk);
    while (!sec_tick) @(negedge clk);
  endtask

  task automatic t_reset;
    check(sec_tick == 0, "R9 sec_tick", sec_tick, 0);
    check(ft_wave == 0, "R9 ft_wave", ft_wave, 0);
    check(trim_pos == 0, "R9 trim_pos", trim_pos, 0);
  endtask

  task automatic t_clear;
    int n;
    repeat (700) @(negedge clk);
    div_clr = 1'b1; @(posedge clk); @(negedge clk); div_clr = 1'b0;
    check(ft_wave == 0, "R7 wave low after clear", ft_wave, 0);
    n = 1;
    while (!sec_tick) begin @(posedge clk); n++; @(negedge clk); end
    check(n == NOM, "R7 second after clear", n, NOM);
  endtask

  task automatic t_nominal;
    int n;
    wait_sec(0, n); check(n == NOM, "R1 nominal second", n, NOM);
    wait_sec(0, n); check(n == NOM, "R1 nominal second again", n, NOM);
  endtask

  task automatic t_trim(input int pos, input int mag, input bit up, input int exp, input string req);
    int n;
    set_pos(pos, mag, up);
    wait_sec(1, n);
    check(n == exp, req, n, exp);
    check(trim_pos == 6'(exp_pos), "R5 position", trim_pos, exp_pos);
    wait_sec(0, n);
    check(n == NOM, {req, " once only"}, n, NOM);
  endtask

  task automatic t_wrap;
    int start;
    osc_en = 1'b0; trim_mag = '0; start = exp_pos;
    for (int i = 0; i < 64; i++) begin
      minute_tick = 1'b1; @(negedge clk); minute_tick = 1'b0; @(negedge clk);
    end
    check(trim_pos == 6'(start), "R5 wrap after 64 minutes", trim_pos, start);
    osc_en = 1'b1;
  endtask

  task automatic t_hold;
    logic w; int n;
    wait_sec(0, n);
    repeat (100) @(negedge clk);
    osc_en = 1'b0; w = ft_wave;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sec_tick) check(0, "R8 tick while stopped", 1, 0);
    end
    check(ft_wave == w, "R8 wave held", ft_wave, w);
    osc_en = 1'b1; n = 100;
    while (!sec_tick) begin @(posedge clk); n++; @(negedge clk); end
    check(n == NOM, "R8 second resumes without loss", n, NOM);
  endtask

  initial begin
    int tmp;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clear();
        t_nominal();
        t_trim(1, 1, 0, NOM + 128, "R3 slowing trim");
        t_trim(5, 3, 1, NOM - 256, "R4 speeding trim");
        t_trim(1, 0, 0, NOM, "R6 magnitude 0 slow");
        t_trim(1, 0, 1, NOM, "R6 magnitude 0 fast");
        t_trim(2, 1, 0, NOM, "R6 position 2 at magnitude 1");
        t_trim(61, 31, 0, NOM + 128, "R6 position 61 at magnitude 31");
        t_trim(62, 31, 1, NOM, "R6 position 62 never trimmed");
        t_wrap();
        t_hold();
        wait_sec(0, tmp);
        check(ft_bad == 0, "R2 half period during trims", ft_bad, 0);
        check(ft_tog > 100, "R2 wave toggling", ft_tog, 101);
      end
      begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule